// File: doc/BRIEF.md
# Serial Byte Shifter with Interrupt Registers

This block is a small memory-mapped peripheral that a host processor uses to move single bytes to and from an external controller over a two-wire serial link: a shift clock driven by the controller, and a data line. The host picks the direction in a mode register, starts each byte by touching the shift data register, and learns that a byte is done from a shift-complete flag. That flag can be routed to an interrupt output through an enable register. The same register file also holds a general-purpose output port with a per-bit direction register.

Registers are selected by address bits 12:9, so consecutive registers are 0x200 bytes apart. Writes happen on the clock edge when the chip select and write enable are high. Reads are combinational while the chip select is high and the write enable is low. A read of the shift data register also has a side effect, which takes place on that edge. The external shift clock and serial input pass through a two-flop synchronizer before the block detects their edges.

Top module: `sr_port_peripheral`

## Requirements
- R1: After reset every register reads 0, except port B data, which returns the pins because all bits are inputs. `irq_o`, `pb_out_o` and `pb_dir_o` are 0.
- R2: The register index is `addr_i[12:9]`. The map is: 0 port B data, 2 port B direction, 10 shift data, 11 mode control, 13 flags, 14 enables. Any other index reads 0, and writes to it change no register.
- R3: A 1 in the port B direction register makes that bit an output. A read of port B data returns the latch on output bits and `pb_in_i` on input bits. `pb_out_o` and `pb_dir_o` show the latch and the direction register.
- R4: Mode control bits 4:2 select the shift mode: 3'b011 (byte 0x0C) shifts in, and 3'b111 (byte 0x1C) shifts out. Under any other value, edges of the shift clock neither move data nor set the flag. The whole byte reads back.
- R5: In shift-in mode, the synchronized serial input is shifted in MSB first on each rising edge of the synchronized shift clock. After the eighth rising edge the byte can be read from shift data, and flag bit 2 is set.
- R6: In shift-out mode, a write to shift data loads the byte and `sdata_o` shows bit 7 at once. Each falling edge of the synchronized shift clock advances `sdata_o` to the next lower bit. After the eighth falling edge, flag bit 2 is set and shift data reads back the original byte.
- R7: Any access to shift data, read or write, clears flag bit 2 and restarts the count of eight edges.
- R8: A write to the flag register clears flag bit 2 when `wdata_i[2]` is 1, and leaves it unchanged when that bit is 0.
- R9: A write to the enable register with bit 7 set turns on the enable bits that are 1 in bits 6:0. With bit 7 clear, it turns those bits off. The enable register reads back with bit 7 as 0.
- R10: `irq_o` is high exactly when flag bit 2 and enable bit 2 are both 1. Bit 7 of the flag register reads the same value.
- R11: Once eight edges have completed, further shift clock edges change neither the data nor the flag until the next access to shift data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Address bits 12:9, the register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request, active high |
| sclk_i | input | 1 | External shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data in (asynchronous) |
| sdata_o | output | 1 | Serial data out, MSB of the shift register |
| pb_in_i | input | 8 | Port B pin levels |
| pb_out_o | output | 8 | Port B output latch |
| pb_dir_o | output | 8 | Port B direction, 1 = output |

## Verification
Random bytes are shifted in, and the collected byte is compared with the serial pattern the bench drove. This separates MSB-first from LSB-first ordering and exposes a wrong edge or a wrong count. Random bytes are also shifted out, and `sdata_o` is sampled before each falling edge, which shows both the bit order and the edge on which it advances. Directed cases restart a shift halfway through a byte, apply edges after completion and under a disabled mode, and walk the set/clear enable writes together with the write-one-to-clear flag. These cases tell apart a restart that does not reset the count, extra shifts after eight edges, and confusion between set and clear. Random port B direction, latch and pin patterns confirm the per-bit choice between pin and latch.

// File: rtl/sr_port_pkg.sv
package sr_port_pkg;
  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_PB_DATA = 4'd0;
  localparam logic [IDX_W-1:0] IDX_PB_DIR  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_SDATA   = 4'd10;
  localparam logic [IDX_W-1:0] IDX_MODE    = 4'd11;
  localparam logic [IDX_W-1:0] IDX_FLAGS   = 4'd13;
  localparam logic [IDX_W-1:0] IDX_ENABLE  = 4'd14;
  localparam logic [2:0] MODE_EXT_IN  = 3'b011;
  localparam logic [2:0] MODE_EXT_OUT = 3'b111;
  localparam int unsigned SHIFT_IRQ_BIT = 2;
  localparam int unsigned NUM_FLAGS = 7;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sr_shift_engine.sv
module sr_shift_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         mode_in_i,
  input  logic         mode_out_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sdi_i,
  output logic [W-1:0] sr_o,
  output logic         done_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             step_in, step_out, step;

  assign step_in  = active_q && mode_in_i  && rise_i;
  assign step_out = active_q && mode_out_i && fall_i;
  assign step     = (step_in || step_out) && !restart_i;
  assign done_o   = step && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      if (load_i) sr_q <= load_data_i;
    end else if (step) begin
      // shift-in fills from the line; shift-out rotates so the byte survives
      sr_q  <= {sr_q[W-2:0], step_in ? sdi_i : sr_q[W-1]};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/sr_irq_ctrl.sv
module sr_irq_ctrl #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic         en_set_i,
  input  logic [N-1:0] en_mask_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] enables_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr_i);
      if (en_we_i) en_q <= en_set_i ? (en_q | en_mask_i) : (en_q & ~en_mask_i);
    end
  end

  assign flags_o   = flag_q;
  assign enables_o = en_q;
  assign irq_o     = |(flag_q & en_q);
endmodule

// File: rtl/sr_port_peripheral.sv
module sr_port_peripheral
  import sr_port_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [12:9]   addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  input  logic          sclk_i,
  input  logic          sdata_i,
  output logic          sdata_o,
  input  logic [DW-1:0] pb_in_i,
  output logic [DW-1:0] pb_out_o,
  output logic [DW-1:0] pb_dir_o
);
  logic [IDX_W-1:0] idx;
  logic wr, rd;
  logic [DW-1:0] pb_q, pb_dir_q, mode_q, sr;
  logic [2:0] mode_sel;
  logic [1:0] sync_q;
  logic sclk_s, sdi_s, sclk_prev_q, sclk_rise, sclk_fall;
  logic sd_access, done;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flags, enables;

  assign idx = addr_i;
  assign wr  = cs_i && we_i;
  assign rd  = cs_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_q     <= '0;
      pb_dir_q <= '0;
      mode_q   <= '0;
    end else if (wr) begin
      case (idx)
        IDX_PB_DATA: pb_q     <= wdata_i;
        IDX_PB_DIR:  pb_dir_q <= wdata_i;
        IDX_MODE:    mode_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  sr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdata_i, sclk_i}),
    .q_o   (sync_q)
  );
  assign sclk_s = sync_q[0];
  assign sdi_s  = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_prev_q;
  assign sclk_fall = !sclk_s && sclk_prev_q;

  assign mode_sel  = mode_q[4:2];
  assign sd_access = cs_i && (idx == IDX_SDATA);

  sr_shift_engine #(.W(DW)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (sd_access),
    .load_i     (we_i),
    .load_data_i(wdata_i),
    .mode_in_i  (mode_sel == MODE_EXT_IN),
    .mode_out_i (mode_sel == MODE_EXT_OUT),
    .rise_i     (sclk_rise),
    .fall_i     (sclk_fall),
    .sdi_i      (sdi_s),
    .sr_o       (sr),
    .done_o     (done)
  );

  always_comb begin
    set_v = '0;
    set_v[SHIFT_IRQ_BIT] = done;
    clr_v = (wr && idx == IDX_FLAGS) ? wdata_i[NUM_FLAGS-1:0] : '0;
    if (sd_access) clr_v[SHIFT_IRQ_BIT] = 1'b1;
  end

  sr_irq_ctrl #(.N(NUM_FLAGS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .clr_i    (clr_v),
    .en_we_i  (wr && idx == IDX_ENABLE),
    .en_set_i (wdata_i[DW-1]),
    .en_mask_i(wdata_i[NUM_FLAGS-1:0]),
    .flags_o  (flags),
    .enables_o(enables),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (idx)
        IDX_PB_DATA: rdata_o = (pb_q & pb_dir_q) | (pb_in_i & ~pb_dir_q);
        IDX_PB_DIR:  rdata_o = pb_dir_q;
        IDX_SDATA:   rdata_o = sr;
        IDX_MODE:    rdata_o = mode_q;
        IDX_FLAGS:   rdata_o = {irq_o, flags};
        IDX_ENABLE:  rdata_o = {1'b0, enables};
        default:     rdata_o = '0;
      endcase
    end
  end

  assign sdata_o  = sr[DW-1];
  assign pb_out_o = pb_q;
  assign pb_dir_o = pb_dir_q;
endmodule

// File: rtl/sr_port_checker.sv
module sr_port_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_i,
  input logic        we_i,
  input logic [3:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        irq_o,
  input logic        sdata_o,
  input logic [7:0]  pb_out_o,
  input logic        flag_sr,
  input logic        done,
  input logic        rise_s,
  input logic        fall_s
);
  a_r10_flag_bit7_is_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && addr_i == 4'd13) |-> (rdata_o[7] == irq_o));

  a_r7_access_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && addr_i == 4'd10) |=> !flag_sr);

  a_r8_w1c_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == 4'd13 && wdata_i[2] && !done) |=> !flag_sr);

  a_r9_disable_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == 4'd14 && !wdata_i[7] && wdata_i[2]) |=> !irq_o);

  a_r6_sdo_holds_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_s && !rise_s && !(cs_i && we_i && addr_i == 4'd10)) |=> $stable(sdata_o));

  a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i && addr_i == 4'd0) |=> $stable(pb_out_o));
endmodule

bind sr_port_peripheral sr_port_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .sdata_o (sdata_o),
  .pb_out_o(pb_out_o),
  .flag_sr (flags[2]),
  .done    (done),
  .rise_s  (sclk_rise),
  .fall_s  (sclk_fall)
);

// File: tb/sim_sr_port_peripheral.sv
module sim_sr_port_peripheral;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pb_in = 8'hA5, pb_out, pb_dir;
  logic irq, sclk = 1'b0, sdi = 1'b0, sdo;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sr_port_peripheral u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sclk_i(sclk),
    .sdata_i(sdi), .sdata_o(sdo), .pb_in_i(pb_in), .pb_out_o(pb_out),
    .pb_dir_o(pb_dir)
  );

  function automatic logic [7:0] pb_expect(input logic [7:0] lat, dir, pins);
    return (lat & dir) | (pins & ~dir);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = idx; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = idx;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic pulse(input logic b, output logic seen);
    @(negedge clk); sdi = b; sclk = 1'b1;
    repeat (4) @(negedge clk);
    seen = sdo; sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, b;
    logic s;
    void'($urandom(32'h1D5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d);  check("R1 pb reads pins", d, 8'hA5);
    rd(4'd2, d);  check("R1 dir", d, 8'h00);
    rd(4'd10, d); check("R1 sdata", d, 8'h00);
    rd(4'd11, d); check("R1 mode", d, 8'h00);
    rd(4'd13, d); check("R1 flags", d, 8'h00);
    rd(4'd14, d); check("R1 enables", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);

    // R2 unmapped indices
    wr(4'd5, 8'hFF); rd(4'd5, d); check("R2 unmapped read", d, 8'h00);
    wr(4'd1, 8'hFF); rd(4'd11, d); check("R2 no alias to mode", d, 8'h00);
    rd(4'd14, d); check("R2 no alias to enables", d, 8'h00);

    // R3 port B random
    for (int i = 0; i < 10; i++) begin
      logic [7:0] lat, dir;
      lat = 8'($urandom); dir = 8'($urandom); pb_in = 8'($urandom);
      wr(4'd2, dir); wr(4'd0, lat);
      rd(4'd0, d); check("R3 pb read", d, pb_expect(lat, dir, pb_in));
      check("R3 pb_out", pb_out, lat);
      check("R3 pb_dir", pb_dir, dir);
    end

    // R5 shift-in random
    wr(4'd11, 8'h0C); rd(4'd11, d); check("R4 mode readback", d, 8'h0C);
    for (int i = 0; i < 12; i++) begin
      b = 8'($urandom);
      rd(4'd10, d);
      for (int k = 7; k >= 0; k--) pulse(b[k], s);
      rd(4'd13, d); check("R5 flag after 8 rises", d, 8'h04);
      rd(4'd10, d); check("R5 byte in", d, b);
      rd(4'd13, d); check("R7 read clears flag", d, 8'h00);
    end

    // R11 edges after completion
    b = 8'h3C;
    rd(4'd10, d);
    for (int k = 7; k >= 0; k--) pulse(b[k], s);
    wr(4'd13, 8'h7B); rd(4'd13, d); check("R8 w1c bit2=0 keeps", d, 8'h04);
    wr(4'd13, 8'h04); rd(4'd13, d); check("R8 w1c clears", d, 8'h00);
    for (int k = 0; k < 8; k++) pulse(1'b1, s);
    rd(4'd13, d); check("R11 no flag after done", d, 8'h00);
    rd(4'd10, d); check("R11 data unchanged", d, b);

    // R7 restart mid byte
    rd(4'd10, d);
    for (int k = 0; k < 4; k++) pulse(1'b0, s);
    wr(4'd10, 8'h00);
    for (int k = 0; k < 7; k++) pulse(1'b1, s);
    rd(4'd13, d); check("R7 restart count 7 edges", d, 8'h00);
    pulse(1'b1, s);
    rd(4'd13, d); check("R7 restart count 8 edges", d, 8'h04);

    // R6 shift-out random
    wr(4'd11, 8'h1C);
    for (int i = 0; i < 12; i++) begin
      b = 8'($urandom);
      wr(4'd10, b);
      check("R6 msb at load", {7'd0, sdo}, {7'd0, b[7]});
      for (int k = 7; k >= 0; k--) begin
        pulse(1'b0, s);
        check("R6 serial bit", {7'd0, s}, {7'd0, b[k]});
      end
      rd(4'd13, d); check("R6 flag after 8 falls", d, 8'h04);
      rd(4'd10, d); check("R6 byte restored", d, b);
    end

    // R9 / R10 enable logic
    wr(4'd14, 8'h84); rd(4'd14, d); check("R9 set", d, 8'h04);
    wr(4'd14, 8'h83); rd(4'd14, d); check("R9 set more", d, 8'h07);
    wr(4'd14, 8'h01); rd(4'd14, d); check("R9 clear", d, 8'h06);
    wr(4'd10, 8'hA1);
    for (int k = 0; k < 8; k++) pulse(1'b0, s);
    check("R10 irq high", {7'd0, irq}, 8'h01);
    rd(4'd13, d); check("R10 bit7", d, 8'h84);
    wr(4'd14, 8'h04);
    check("R10 irq masked", {7'd0, irq}, 8'h00);
    rd(4'd13, d); check("R10 bit7 masked", d, 8'h04);

    // R4 disabled mode ignores edges
    wr(4'd10, 8'h5A);
    wr(4'd11, 8'h08);
    for (int k = 0; k < 8; k++) pulse(1'b1, s);
    rd(4'd13, d); check("R4 no flag in other mode", d, 8'h00);
    rd(4'd10, d); check("R4 data kept", d, 8'h5A);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule